// File: doc/BRIEF.md
# I2C Serial Memory Page-Write Slave

This block is the write path of a serial memory that sits on a two-wire I2C bus. A bus master addresses it with a control byte. If the slave takes the control byte, the master sends a two-byte word address and then one or more data bytes. The data bytes are not written to the storage array at once. They are collected in a page staging buffer, and the pointer inside that buffer only moves within the current page, so a long burst wraps around and overwrites bytes it sent earlier in the same transfer.

A STOP that follows at least one data byte starts a self-timed commit. The commit copies every staged byte into the 4096-byte array, one byte per system clock. It lasts `WRITE_CYCLES` system clocks in total. While it runs, the slave answers no control byte. The bus lines arrive as separate in, out and output-enable signals, and both are sampled on the system clock. The rest of the chip reads the array contents through a registered read port.

Top module: `i2cee_page_writer`

## Requirements
- R1: A control byte is acknowledged only when its upper nibble is 4'b1010, bits [3:1] equal `dev_sel` and bit 0 (direction) is 0. Any other control byte gets no acknowledge, and every byte after it is left unacknowledged until the next START.
- R2: For each byte it accepts, the slave pulls SDA low (`sda_oe`=1, `sda_o`=0) from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit. At all other times `sda_oe` is 0.
- R3: The byte after an accepted control byte carries address bits [11:8] in its low nibble. Its high nibble is ignored. The next byte carries address bits [7:0].
- R4: Each data byte is staged at the current in-page offset, the address low 5 bits. After each data byte only that 5-bit offset increments, wrapping from 31 to 0. A later byte at the same offset replaces the earlier one.
- R5: A STOP after at least one data byte writes exactly the staged offsets of the addressed 32-byte page into the array. Every other location keeps its previous contents.
- R6: A STOP before any data byte writes nothing and does not start a commit.
- R7: After a commit starts, control bytes are not acknowledged for `WRITE_CYCLES` system clocks. After that they are acknowledged again.
- R8: A START at any point, including inside a byte, restarts byte framing so that the next byte is taken as a control byte.
- R9: While reset is high and after it is released, `sda_oe` is 0 and the slave waits for a START.
- R10: `rd_data` shows the array byte at `rd_addr` one system clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_o | output | 1 | SDA drive value, always 0 (open drain) |
| sda_oe | output | 1 | SDA pull-down enable, used for acknowledge |
| dev_sel | input | 3 | Hardware device-select strap |
| rd_addr | input | 12 | Array read address from the chip side |
| rd_data | output | 8 | Registered array read data |

## Verification
The in-RTL assertions check four things on every cycle. The acknowledge drive only ever rises on a synchronized SCL falling edge. A data byte advances the in-page offset by exactly one and leaves the page bits unchanged. A qualifying STOP raises the commit-busy state. No control byte is acknowledged while busy. Some behaviours can only be shown by the bench's scenarios, which compare every acknowledge bit and the array contents against a behavioural model: wrap-around overwrite in long bursts, partial-page preservation, rejection by select field, code or direction, resynchronization on a START inside a byte, and the no-write result of an address-only transfer.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } i2cee_state_t;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/i2cee_line_sync.sv
module i2cee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cee_page_buf.sv
module i2cee_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DW         = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [OFF_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             any_valid
);
  logic [DW-1:0]         slots [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  valid <= '0;
    else if (wr_en)  valid[wr_idx] <= 1'b1;
  end

  assign rd_data   = slots[rd_idx];
  assign rd_valid  = valid[rd_idx];
  assign any_valid = |valid;
endmodule

// File: rtl/i2cee_mem.sv
module i2cee_mem #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/i2cee_page_writer.sv
module i2cee_page_writer
  import i2cee_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int OFF_W   = $clog2(PAGE_BYTES);
  localparam int HI_BITS = ADDR_W - 8;
  localparam int WC_W    = $clog2(WRITE_CYCLES + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  i2cee_state_t st;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [HI_BITS-1:0] hi_q;
  logic [ADDR_W-1:0] ptr;
  logic sda_oe_q, busy;
  logic [WC_W-1:0] wcnt;
  logic active, byte_done, ctrl_ok, buf_we, buf_clr;
  logic [7:0] buf_rd;
  logic buf_rd_valid, any_valid, mem_we;
  logic [OFF_W-1:0] cidx;

  i2cee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign active    = (st == ST_CTRL) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_DATA);
  assign byte_done = active && scl_fall && (bit_cnt == 4'd8) && !start_det && !stop_det;
  assign ctrl_ok   = (shreg[7:4] == CTRL_CODE) && (shreg[3:1] == dev_sel) && !shreg[0] && !busy;
  assign buf_we    = byte_done && (st == ST_DATA);
  assign buf_clr   = byte_done && (st == ST_ALO);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      hi_q     <= '0;
      ptr      <= '0;
      sda_oe_q <= 1'b0;
    end else if (start_det) begin
      st       <= ST_CTRL;
      bit_cnt  <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      sda_oe_q <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt < 4'd8) begin
        shreg   <= {shreg[6:0], sda_s};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_rise && bit_cnt == 4'd8) begin
        bit_cnt <= 4'd9;
      end else if (scl_fall && bit_cnt == 4'd9) begin
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
      end else if (byte_done) begin
        case (st)
          ST_CTRL: begin
            if (ctrl_ok) begin
              sda_oe_q <= 1'b1;
              st       <= ST_AHI;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_AHI: begin
            hi_q     <= shreg[HI_BITS-1:0];
            sda_oe_q <= 1'b1;
            st       <= ST_ALO;
          end
          ST_ALO: begin
            ptr      <= {hi_q, shreg};
            sda_oe_q <= 1'b1;
            st       <= ST_DATA;
          end
          default: begin
            sda_oe_q         <= 1'b1;
            ptr[OFF_W-1:0]   <= ptr[OFF_W-1:0] + OFF_W'(1);
          end
        endcase
      end
    end
  end

  // Self-timed commit: one staged slot per clock, then idle until the count ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      wcnt <= '0;
    end else if (!busy) begin
      if (stop_det && st == ST_DATA && any_valid) begin
        busy <= 1'b1;
        wcnt <= '0;
      end
    end else begin
      wcnt <= wcnt + WC_W'(1);
      if (wcnt == WC_W'(WRITE_CYCLES - 1)) busy <= 1'b0;
    end
  end

  assign cidx   = wcnt[OFF_W-1:0];
  assign mem_we = busy && (32'(wcnt) < PAGE_BYTES) && buf_rd_valid;

  i2cee_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DW(8)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr_en(buf_we),
    .wr_idx(ptr[OFF_W-1:0]), .wr_data(shreg), .rd_idx(cidx),
    .rd_data(buf_rd), .rd_valid(buf_rd_valid), .any_valid(any_valid)
  );

  i2cee_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr({ptr[ADDR_W-1:OFF_W], cidx}), .wdata(buf_rd),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign sda_oe = sda_oe_q;
  assign sda_o  = 1'b0;

  // R2
  ack_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_q) |-> $past(scl_fall));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> (ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + 1)));
  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> $stable(ptr[ADDR_W-1:OFF_W]));
  // R5
  commit_start_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_det && st == ST_DATA && any_valid && !busy) |=> busy);
  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && st == ST_CTRL && busy) |=> !sda_oe_q);
endmodule

// File: tb/tb_i2cee_page_writer.sv
module tb_i2cee_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int WC = 600;
  localparam logic [2:0] DEV = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic line_sda;
  logic sda_o, sda_oe;
  logic [11:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0, fails = 0, mon_bad = 0;
  bit done = 0, oe_allowed = 0;
  logic [7:0] model_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line_sda = m_sda & ~(sda_oe & ~sda_o);

  i2cee_page_writer #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(line_sda), .sda_o(sda_o),
    .sda_oe(sda_oe), .dev_sel(DEV), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: pull-down allowed only inside the acknowledge window
  always @(negedge clk) if (!rst && sda_oe && !oe_allowed) mon_bad++;

  task automatic bus_start();
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0;
      if (i == 0) oe_allowed = 1;
      tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); ack = !line_sda; tick(Q); m_scl = 0; tick(Q);
    oe_allowed = 0;
  endtask

  task automatic write_txn(input logic [7:0] ctrl, input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] dq[$], input bit exp_ack, input string req,
                           input bit do_stop);
    bit a;
    int base, off;
    bus_start();
    send_byte(ctrl, a); check(a == exp_ack, {req, " ctrl ack"}, a, exp_ack);
    send_byte(hi, a);   check(a == exp_ack, {req, " addr-hi ack R3"}, a, exp_ack);
    send_byte(lo, a);   check(a == exp_ack, {req, " addr-lo ack R3"}, a, exp_ack);
    foreach (dq[i]) begin
      send_byte(dq[i], a);
      check(a == exp_ack, {req, " data ack R2"}, a, exp_ack);
    end
    if (do_stop) bus_stop();
    if (exp_ack && dq.size() > 0) begin
      base = {hi[3:0], lo} & 32'hFE0;
      off  = lo[4:0];
      foreach (dq[i]) begin
        model_mem[base + off] = dq[i];
        off = (off + 1) % 32;
      end
      if (do_stop) tick(WC + 50);
    end
  endtask

  task automatic verify_mem(input string req);
    foreach (model_mem[a]) begin
      rd_addr = 12'(a);
      tick(1);
      check(rd_data === model_mem[a], req, rd_data, model_mem[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] dq[$];
    logic [7:0] good;
    bit a;
    good = {4'hA, DEV, 1'b0};
    tick(5);
    check(sda_oe == 0, "R9 reset oe", sda_oe, 0);
    rst = 0; tick(5);
    check(sda_oe == 0, "R9 idle oe", sda_oe, 0);

    // single byte write, high nibble ignored
    dq = '{8'h5A};
    write_txn(good, 8'hF1, 8'h23, dq, 1, "R1 R3", 1);
    verify_mem("R3 R5 single byte, high nibble ignored");

    // full page from offset 8 wraps inside page
    dq.delete(); for (int i = 0; i < 32; i++) dq.push_back(8'(8'h40 + i));
    write_txn(good, 8'h02, 8'hE8, dq, 1, "R4 wrap", 1);
    verify_mem("R4 page wrap");

    // 40-byte burst overwrites first staged offsets
    dq.delete(); for (int i = 0; i < 40; i++) dq.push_back(8'(8'h80 + i));
    write_txn(good, 8'h04, 8'h00, dq, 1, "R4 overrun", 1);
    verify_mem("R4 overrun overwrite");

    // partial write keeps neighbours in the page
    dq = '{8'hC1, 8'hC2, 8'hC3};
    write_txn(good, 8'h02, 8'hF0, dq, 1, "R5 partial", 1);
    verify_mem("R5 untouched locations kept");

    // wrong select, wrong code, read direction: all ignored
    dq = '{8'hEE};
    write_txn({4'hA, DEV ^ 3'b001, 1'b0}, 8'h01, 8'h23, dq, 0, "R1 select", 1);
    write_txn({4'hB, DEV, 1'b0}, 8'h02, 8'hF0, dq, 0, "R1 code", 1);
    write_txn({4'hA, DEV, 1'b1}, 8'h04, 8'h00, dq, 0, "R1 dir", 1);
    verify_mem("R1 ignored bytes left array unchanged");

    // busy window
    dq = '{8'h77};
    write_txn(good, 8'h07, 8'h00, dq, 1, "R7 setup", 0);
    bus_stop();
    bus_start(); send_byte(good, a); bus_stop();
    check(a == 0, "R7 nack while busy", a, 0);
    tick(WC + 50);
    bus_start(); send_byte(good, a); bus_stop();
    check(a == 1, "R7 ack after busy", a, 1);
    verify_mem("R7 commit done");

    // address-only transfer: no commit, next control byte acked at once
    dq.delete();
    write_txn(good, 8'h01, 8'h23, dq, 1, "R6 setup", 1);
    bus_start(); send_byte(good, a); bus_stop();
    check(a == 1, "R6 no busy after address-only", a, 1);
    verify_mem("R6 nothing written");

    // START inside a byte restarts framing
    bus_start(); send_bits(8'hA5, 4); m_scl = 0;
    dq = '{8'h3C};
    write_txn(good, 8'h09, 8'h1F, dq, 1, "R8 restart", 1);
    verify_mem("R8 write after mid-byte START");

    // read port latency
    rd_addr = 12'h123; @(posedge clk); #1;
    check(rd_data == 8'h5A, "R10 read latency", rd_data, 8'h5A);

    check(mon_bad == 0, "R2 oe outside ack window", mon_bad, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule